// File: doc/BRIEF.md
# Converter Chip-Select Serial Output Port

This block is the digital readout side of an 18-bit successive-approximation converter that works in a four-wire chip-select arrangement with no busy flag. A convert strobe, a per-device select line and a host serial clock arrive from outside. All three are sampled by a faster system clock, and edge detection runs on the synchronised copies. A rising convert strobe with select high starts a conversion. A behavioural timer stands in for the conversion: it captures the parallel sample input and finishes after a parameterised number of system clocks. The phase output shows acquisition, conversion or readout.

When select goes low after the conversion has ended, while the strobe is still high, the port puts the result MSB on the serial output at once. Each falling edge of the serial clock then moves on to the next lower bit. The output turns off after the last bit or when select rises, whichever comes first. Several ports can therefore share one serial data wire, each gated by its own select line. The output pin has a separate enable for a tri-state pad. The serial stream is paced only by the host clock and has no back-pressure: the host reads bits whenever it wants. The parallel sample has no handshake, because the convert strobe marks when it is taken.

Top module: `sar_cs_serial_port`

## Requirements
- R1: After reset the phase is acquisition (code 0), the output enable is low and the protocol-error flag is low.
- R2: A convert-strobe rising edge while select is high starts a conversion: the phase becomes conversion (code 1), the output enable stays low, and the sample input is captured as the result.
- R3: The conversion ends CONV_CYCLES system clocks after it starts, and the phase returns to acquisition.
- R4: In acquisition, with an unread result and the strobe high, a select falling edge enters readout (code 2), raises the output enable and presents result bit 17 on the serial output.
- R5: Each serial-clock falling edge during readout presents the next lower result bit, so the word goes out MSB first, down to bit 0.
- R6: The 18th serial-clock falling edge of a readout ends it: the phase returns to acquisition and the output enable drops.
- R7: A select rising edge during readout ends it at once, and the output enable drops.
- R8: A select falling edge during conversion does not enable the output. It sets the protocol-error flag, which stays set until the next conversion starts.
- R9: In acquisition, with both select and strobe low, the output is driven low (enable high, data 0).
- R10: A strobe rising edge during readout aborts it and releases the output. It takes priority over a serial-clock falling edge in the same cycle.
- R11: A result can be read only once. After any readout ends, a new select falling edge with the strobe high leaves the output disabled until another conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_i | input | 1 | Convert strobe, asynchronous |
| sel_i | input | 1 | Device select; low selects the device for readout |
| sck_i | input | 1 | Host serial clock, asynchronous |
| sample_i | input | RES_W | Parallel value the conversion stub captures |
| sdo_o | output | 1 | Serial data |
| sdo_oe_o | output | 1 | Output enable for the tri-state serial data pad |
| phase_o | output | 2 | 0 acquisition, 1 conversion, 2 readout |
| proto_err_o | output | 1 | Set by a select fall during conversion |

## Verification
Two events can land in the same system-clock cycle: a serial-clock falling edge that would shift the word, and a convert-strobe rising edge that aborts the readout. The bench lowers the serial clock and raises the strobe at the same instant in the middle of a word. Both signals pass through synchronisers of equal depth, so the two edges reach the control logic together. The test passes when the phase returns to acquisition with the output released and the unread result discarded, rather than the port shifting one more bit and staying in readout.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;
  typedef enum logic [1:0] {
    PH_ACQ  = 2'd0,
    PH_CONV = 2'd1,
    PH_READ = 2'd2
  } phase_e;

  localparam int SIG_CNV = 0;
  localparam int SIG_SEL = 1;
  localparam int SIG_SCK = 2;
  localparam int NUM_SIG = 3;
endpackage

// File: rtl/sar_in_sync.sv
module sar_in_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  input  logic [N-1:0] rst_val_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] prev_o
);
  for (genvar g = 0; g < N; g++) begin : g_sig
    logic [STAGES-1:0] chain;
    logic              last_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain  <= {STAGES{rst_val_i[g]}};
        last_q <= rst_val_i[g];
      end else begin
        chain  <= {chain[STAGES-2:0], async_i[g]};
        last_q <= chain[STAGES-1];
      end
    end
    assign lvl_o[g]  = chain[STAGES-1];
    assign prev_o[g] = last_q;
  end
endmodule

// File: rtl/sar_conv_timer.sv
module sar_conv_timer #(
  parameter int RES_W       = 18,
  parameter int CONV_CYCLES = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [RES_W-1:0] sample_i,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      busy     <= 1'b0;
      result_o <= '0;
    end else if (start_i) begin
      cnt      <= LOAD;
      busy     <= 1'b1;
      result_o <= sample_i;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done_o = busy && (cnt == '0);

  // R2: a new conversion is only requested once the previous one finished
  p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy);
endmodule

// File: rtl/sar_out_shifter.sv
module sar_out_shifter #(
  parameter int RES_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [RES_W-1:0] data_i,
  output logic             bit_o,
  output logic             last_o
);
  localparam int IW = $clog2(RES_W);
  localparam logic [IW-1:0] TOP = IW'(RES_W - 1);

  logic [RES_W-1:0] sreg;
  logic [IW-1:0]    left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      left <= '0;
    end else if (load_i) begin
      sreg <= data_i;
      left <= TOP;
    end else if (shift_i) begin
      sreg <= {sreg[RES_W-2:0], 1'b0};
      left <= left - 1'b1;
    end
  end

  assign bit_o  = sreg[RES_W-1];
  assign last_o = (left == '0);

  // R5: the controller never shifts beyond bit 0
  p_shift_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |-> !last_o);
endmodule

// File: rtl/sar_cs_serial_port.sv
module sar_cs_serial_port
  import sar_port_pkg::*;
#(
  parameter int RES_W       = 18,
  parameter int CONV_CYCLES = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnv_i,
  input  logic             sel_i,
  input  logic             sck_i,
  input  logic [RES_W-1:0] sample_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic [1:0]       phase_o,
  output logic             proto_err_o
);
  logic [NUM_SIG-1:0] raw, lvl, prev, rst_val;

  assign raw[SIG_CNV]     = cnv_i;
  assign raw[SIG_SEL]     = sel_i;
  assign raw[SIG_SCK]     = sck_i;
  assign rst_val[SIG_CNV] = 1'b0;
  assign rst_val[SIG_SEL] = 1'b1;
  assign rst_val[SIG_SCK] = 1'b0;

  sar_in_sync #(.N(NUM_SIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(raw), .rst_val_i(rst_val),
    .lvl_o(lvl), .prev_o(prev));

  logic cnv_lvl, sel_lvl, cnv_rise, sel_rise, sel_fall, sck_fall;
  assign cnv_lvl  = lvl[SIG_CNV];
  assign sel_lvl  = lvl[SIG_SEL];
  assign cnv_rise = lvl[SIG_CNV] & ~prev[SIG_CNV];
  assign sel_rise = lvl[SIG_SEL] & ~prev[SIG_SEL];
  assign sel_fall = ~lvl[SIG_SEL] & prev[SIG_SEL];
  assign sck_fall = ~lvl[SIG_SCK] & prev[SIG_SCK];

  phase_e           st;
  logic             have_res, err_q;
  logic             conv_start, conv_done, ld, sh, cur_bit, last_bit;
  logic [RES_W-1:0] res;

  sar_conv_timer #(.RES_W(RES_W), .CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(conv_start), .sample_i(sample_i),
    .done_o(conv_done), .result_o(res));

  sar_out_shifter #(.RES_W(RES_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(ld), .shift_i(sh), .data_i(res),
    .bit_o(cur_bit), .last_o(last_bit));

  assign conv_start = (st == PH_ACQ) && cnv_rise && sel_lvl;
  assign ld = (st == PH_ACQ) && !conv_start && sel_fall && cnv_lvl && have_res;
  assign sh = (st == PH_READ) && !cnv_rise && !sel_rise && sck_fall && !last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= PH_ACQ;
      have_res <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      unique case (st)
        PH_ACQ: begin
          if (conv_start) begin
            st       <= PH_CONV;
            have_res <= 1'b0;
            err_q    <= 1'b0;
          end else if (ld) begin
            st <= PH_READ;
          end
        end
        PH_CONV: begin
          if (sel_fall) err_q <= 1'b1;
          if (conv_done) begin
            st       <= PH_ACQ;
            have_res <= 1'b1;
          end
        end
        PH_READ: begin
          if (cnv_rise || sel_rise || (sck_fall && last_bit)) begin
            st       <= PH_ACQ;
            have_res <= 1'b0;
          end
        end
        default: st <= PH_ACQ;
      endcase
    end
  end

  assign sdo_oe_o    = (st == PH_READ) || ((st == PH_ACQ) && !sel_lvl && !cnv_lvl);
  assign sdo_o       = (st == PH_READ) ? cur_bit : 1'b0;
  assign phase_o     = st;
  assign proto_err_o = err_q;

  // R4: entering readout puts the result MSB on the line
  p_read_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (st == PH_READ) && sdo_oe_o && (sdo_o == $past(res[RES_W-1])));
  // R6: the final falling edge leaves readout with the result consumed
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == PH_READ) && sck_fall && last_bit) |=> (st == PH_ACQ) && !have_res);
  // R8: a select fall during conversion flags an error
  p_err_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == PH_CONV) && sel_fall) |=> proto_err_o);
  // R10: a strobe rise during readout aborts it
  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == PH_READ) && cnv_rise) |=> (st == PH_ACQ));
  // R11: without an unread result no readout can begin
  p_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == PH_ACQ) && !have_res) |=> (st != PH_READ));
endmodule

// File: tb/sar_cs_serial_port_tb.sv
module sar_cs_serial_port_tb;
  localparam int RES_W  = 18;
  localparam int CONV   = 40;
  localparam int SETTLE = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnv = 1'b0, sel = 1'b1, sck = 1'b0;
  logic [RES_W-1:0] sample = '0;
  logic sdo, sdo_oe, perr;
  logic [1:0] phase;

  int n_chk = 0, n_fail = 0;
  logic exp_q[$];
  event smp_ev;

  always #2 clk = ~clk;

  sar_cs_serial_port #(.RES_W(RES_W), .CONV_CYCLES(CONV)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .sel_i(sel), .sck_i(sck),
    .sample_i(sample), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .phase_o(phase),
    .proto_err_o(perr));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic sck_pulse;
    sck = 1'b1; step(4);
    sck = 1'b0; step(SETTLE);
  endtask

  task automatic convert(input logic [RES_W-1:0] v);
    sample = v;
    cnv = 1'b0; step(SETTLE);
    cnv = 1'b1; step(SETTLE);
    chk("R2 phase", 32'(phase), 32'd1);
    chk("R2 oe", 32'(sdo_oe), 32'd0);
    step(CONV + 2);
    chk("R3 phase", 32'(phase), 32'd0);
  endtask

  // driver: queue expected bits, then select and clock
  task automatic read_bits(input logic [RES_W-1:0] v, input int nbits);
    for (int i = RES_W - 1; i >= RES_W - nbits; i--) exp_q.push_back(v[i]);
    sel = 1'b0; step(SETTLE);
    chk("R4 phase", 32'(phase), 32'd2);
    -> smp_ev; #0;
    for (int i = 1; i < nbits; i++) begin
      sck_pulse();
      -> smp_ev; #0;
    end
  endtask

  // monitor: compare each presented bit with the queue
  initial begin
    forever begin
      @(smp_ev);
      chk("R5 oe", 32'(sdo_oe), 32'd1);
      if (exp_q.size() == 0) chk("R5 queue", 32'd0, 32'd1);
      else chk("R5 bit", 32'(sdo), 32'(exp_q.pop_front()));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    step(3); rst_n = 1'b1; step(2);
    chk("R1 phase", 32'(phase), 32'd0);
    chk("R1 oe", 32'(sdo_oe), 32'd0);
    chk("R1 err", 32'(perr), 32'd0);

    // full word, MSB first
    convert(18'h2A5C3);
    read_bits(18'h2A5C3, RES_W);
    sck_pulse();
    chk("R6 oe", 32'(sdo_oe), 32'd0);
    chk("R6 phase", 32'(phase), 32'd0);
    sel = 1'b1; step(SETTLE);
    // R11: result already consumed
    sel = 1'b0; step(SETTLE);
    chk("R11 oe", 32'(sdo_oe), 32'd0);
    chk("R11 phase", 32'(phase), 32'd0);
    sel = 1'b1; step(SETTLE);

    // R9: both low drives zero
    cnv = 1'b0; step(SETTLE);
    sel = 1'b0; step(SETTLE);
    chk("R9 oe", 32'(sdo_oe), 32'd1);
    chk("R9 sdo", 32'(sdo), 32'd0);
    sel = 1'b1; step(SETTLE);

    // R7: early release by select
    convert(18'h1F00F);
    read_bits(18'h1F00F, 5);
    sel = 1'b1; step(SETTLE);
    chk("R7 oe", 32'(sdo_oe), 32'd0);
    chk("R7 phase", 32'(phase), 32'd0);

    // R8: select fall during conversion
    sample = 18'h155AA;
    cnv = 1'b0; step(SETTLE);
    cnv = 1'b1; step(10);
    sel = 1'b0; step(SETTLE);
    chk("R8 oe", 32'(sdo_oe), 32'd0);
    chk("R8 err", 32'(perr), 32'd1);
    chk("R8 phase", 32'(phase), 32'd1);
    sel = 1'b1; step(CONV);
    chk("R8 sticky", 32'(perr), 32'd1);
    chk("R3 done", 32'(phase), 32'd0);
    read_bits(18'h155AA, RES_W);
    sck_pulse();
    chk("R6 oe again", 32'(sdo_oe), 32'd0);
    sel = 1'b1; step(SETTLE);

    // R10: strobe rise coincides with serial-clock fall
    convert(18'h0C3A5);
    chk("R8 cleared", 32'(perr), 32'd0);
    read_bits(18'h0C3A5, 3);
    cnv = 1'b0; step(SETTLE);
    chk("R10 held", 32'(phase), 32'd2);
    sck = 1'b1; step(4);
    sck = 1'b0; cnv = 1'b1; step(SETTLE);
    chk("R10 phase", 32'(phase), 32'd0);
    chk("R10 oe", 32'(sdo_oe), 32'd0);
    sel = 1'b1; step(SETTLE);
    sel = 1'b0; step(SETTLE);
    chk("R11 after abort", 32'(sdo_oe), 32'd0);
    sel = 1'b1; step(SETTLE);

    chk("R5 queue empty", 32'(exp_q.size()), 32'd0);
    report();
  end
endmodule